// File: doc/BRIEF.md
# Shutdown and Reset Input Controller

This block qualifies two active-low control pins, a shutdown pin and an external reset pin. Each pin is brought into the system clock domain and then debounced. Only a level that persists for a programmable number of cycles is accepted.

An accepted shutdown requests power-off for the ports selected by a priority mask. It also sets a sticky flag, which tells the host that it must reload its configuration. An accepted reset requests power-off on every port and a return of all registers to their power-up values. The busy output is held high for the whole reset assertion and for a fixed startup window after release.

While busy is high, host commands are refused. Host command gating is done with a plain accept/reject pair. A separate asynchronous power-on reset clears the whole block on its own and also opens a startup window.

Top module: `sdrst_ctrl`

## Requirements
- R1: Once the power-on reset is released, the outputs are idle: no port-off request, no register-reset request and a clear sticky flag. Busy stays high for exactly BUSY_CYCLES clock edges after power-on reset release, then goes low.
- R2: A level change on either pin takes effect only after it has been sampled on FILT_CYCLES consecutive clock edges. An accepted change shows at the outputs after SYNC_STAGES+FILT_CYCLES edges, counted from the first edge that samples the new level. A low pulse lasting fewer than FILT_CYCLES edges has no effect on any output.
- R3: While shutdown is accepted and reset is not, port_off_req equals prio_mask. Bit i set to 1 means port i is turned off on shutdown.
- R4: While reset is accepted, port_off_req is all ones and reg_reset_req is 1, whatever prio_mask and the shutdown pin are doing.
- R5: Busy is high for the whole time reset is accepted. It stays high for BUSY_CYCLES further edges after the accepted reset is released.
- R6: host_cmd_reject equals host_cmd_req while busy is high, and host_cmd_accept equals host_cmd_req while busy is low. The two are never high together.
- R7: The sticky flag shdn_seen rises on the edge after shutdown is accepted. It is cleared by a sticky_clr pulse only while shutdown is not accepted, and is cleared by an accepted reset. A clear pulse during an accepted shutdown leaves it set.
- R8: Driving por_n low asynchronously forces port_off_req and reg_reset_req to 0, shdn_seen to 0 and busy to 1, whatever the pins are doing.
- R9: Both filtered levels start inactive (high) at power-on reset. A pin that is already low when power-on reset is released takes effect only after SYNC_STAGES+FILT_CYCLES edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| shdn_pin_n | input | 1 | Shutdown pin, active low, asynchronous |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| prio_mask | input | NUM_PORTS | Ports to power off on shutdown (1 = off) |
| host_cmd_req | input | 1 | Host command presented this cycle |
| sticky_clr | input | 1 | Clears the shutdown sticky flag |
| port_off_req | output | NUM_PORTS | Per-port power-off request |
| reg_reset_req | output | 1 | Request to restore registers to power-up values |
| busy | output | 1 | Reset held or startup window running |
| host_cmd_accept | output | 1 | Host command accepted |
| host_cmd_reject | output | 1 | Host command refused while busy |
| shdn_seen | output | 1 | Sticky: a shutdown has been accepted |

## Verification
The hardest case to reach is a pulse that is exactly one edge short of the filter length, compared with one that just reaches it. Only a single edge separates rejection from acceptance, and the synchronizer stages move the effect further away from the stimulus. The stimulus drives pulses of width FILT_CYCLES-1 and FILT_CYCLES as directed cases, plus random widths around that limit. A bench function predicts, edge by edge, when each output changes and when the startup window ends.

// File: rtl/sdrst_pkg.sv
package sdrst_pkg;

   // Reason for a port-off request, highest priority last
   typedef enum logic [1:0] {
      OFF_NONE = 2'd0,
      OFF_SHDN = 2'd1,
      OFF_RST  = 2'd2
   } off_cause_e;

   function automatic off_cause_e pick_cause(input logic shdn_act, input logic rst_act);
      if (rst_act)       return OFF_RST;
      else if (shdn_act) return OFF_SHDN;
      else               return OFF_NONE;
   endfunction

endpackage

// File: rtl/sdrst_deglitch.sv
module sdrst_deglitch #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_CYCLES = 8
) (
   input  logic clk,
   input  logic por_n,
   input  logic pin_n,
   output logic lvl_n
);

   localparam int CW = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES) : 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("sdrst_deglitch: SYNC_STAGES must be at least 2");
      end
      if (FILT_CYCLES < 1) begin : g_bad_filt
         $error("sdrst_deglitch: FILT_CYCLES must be at least 1");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   lvl_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
   end

   wire samp = sync_q[SYNC_STAGES-1];

   generate
      if (FILT_CYCLES == 1) begin : g_direct
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) lvl_q <= 1'b1;
            else        lvl_q <= samp;
         end
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               cnt_q <= '0;
               lvl_q <= 1'b1;
            end else if (samp == lvl_q) begin
               cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_CYCLES - 1)) begin
               cnt_q <= '0;
               lvl_q <= samp;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         // R2
         filt_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
            (lvl_q != $past(lvl_q)) |-> ($past(cnt_q) == CW'(FILT_CYCLES - 1)));
      end
   endgenerate

   assign lvl_n = lvl_q;

endmodule

// File: rtl/sdrst_busy_timer.sv
module sdrst_busy_timer #(
   parameter int BUSY_CYCLES = 100
) (
   input  logic clk,
   input  logic por_n,
   input  logic hold,
   output logic busy
);

   localparam int BW = $clog2(BUSY_CYCLES + 1);

   generate
      if (BUSY_CYCLES < 1) begin : g_bad_busy
         $error("sdrst_busy_timer: BUSY_CYCLES must be at least 1");
      end
   endgenerate

   logic [BW-1:0] cnt_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)              cnt_q <= BW'(BUSY_CYCLES);
      else if (hold)           cnt_q <= BW'(BUSY_CYCLES);
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign busy = hold | (cnt_q != '0);

   // R5
   busy_drop_chk: assert property (@(posedge clk) disable iff (!por_n)
      $fell(busy) |-> ($past(cnt_q) == BW'(1)));

endmodule

// File: rtl/sdrst_off_map.sv
module sdrst_off_map
   import sdrst_pkg::*;
#(
   parameter int NUM_PORTS = 4
) (
   input  logic                 shdn_act,
   input  logic                 rst_act,
   input  logic [NUM_PORTS-1:0] prio_mask,
   output logic [NUM_PORTS-1:0] port_off_req,
   output logic                 reg_reset_req
);

   generate
      if (NUM_PORTS < 1) begin : g_bad_ports
         $error("sdrst_off_map: NUM_PORTS must be at least 1");
      end
   endgenerate

   off_cause_e cause;
   assign cause = pick_cause(shdn_act, rst_act);

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      always_comb begin
         unique case (cause)
            OFF_RST:  port_off_req[p] = 1'b1;
            OFF_SHDN: port_off_req[p] = prio_mask[p];
            default:  port_off_req[p] = 1'b0;
         endcase
      end
   end

   assign reg_reset_req = (cause == OFF_RST);

endmodule

// File: rtl/sdrst_ctrl.sv
module sdrst_ctrl #(
   parameter int NUM_PORTS   = 4,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_CYCLES = 8,
   parameter int BUSY_CYCLES = 100
) (
   input  logic                 clk,
   input  logic                 por_n,
   input  logic                 shdn_pin_n,
   input  logic                 rst_pin_n,
   input  logic [NUM_PORTS-1:0] prio_mask,
   input  logic                 host_cmd_req,
   input  logic                 sticky_clr,
   output logic [NUM_PORTS-1:0] port_off_req,
   output logic                 reg_reset_req,
   output logic                 busy,
   output logic                 host_cmd_accept,
   output logic                 host_cmd_reject,
   output logic                 shdn_seen
);

   logic shdn_lvl_n, rst_lvl_n;
   logic shdn_act, rst_act;
   logic seen_q;

   sdrst_deglitch #(.SYNC_STAGES(SYNC_STAGES), .FILT_CYCLES(FILT_CYCLES)) u_shdn_flt (
      .clk   (clk),
      .por_n (por_n),
      .pin_n (shdn_pin_n),
      .lvl_n (shdn_lvl_n)
   );

   sdrst_deglitch #(.SYNC_STAGES(SYNC_STAGES), .FILT_CYCLES(FILT_CYCLES)) u_rst_flt (
      .clk   (clk),
      .por_n (por_n),
      .pin_n (rst_pin_n),
      .lvl_n (rst_lvl_n)
   );

   assign shdn_act = ~shdn_lvl_n;
   assign rst_act  = ~rst_lvl_n;

   sdrst_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
      .clk   (clk),
      .por_n (por_n),
      .hold  (rst_act),
      .busy  (busy)
   );

   sdrst_off_map #(.NUM_PORTS(NUM_PORTS)) u_map (
      .shdn_act      (shdn_act),
      .rst_act       (rst_act),
      .prio_mask     (prio_mask),
      .port_off_req  (port_off_req),
      .reg_reset_req (reg_reset_req)
   );

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)          seen_q <= 1'b0;
      else if (rst_act)    seen_q <= 1'b0;
      else if (shdn_act)   seen_q <= 1'b1;
      else if (sticky_clr) seen_q <= 1'b0;
   end

   assign shdn_seen       = seen_q;
   assign host_cmd_accept = host_cmd_req & ~busy;
   assign host_cmd_reject = host_cmd_req & busy;

   // R3
   shdn_mask_chk: assert property (@(posedge clk) disable iff (!por_n)
      (shdn_act && !rst_act) |-> ((port_off_req & ~prio_mask) == '0));

   // R4
   rst_all_chk: assert property (@(posedge clk) disable iff (!por_n)
      rst_act |-> ((&port_off_req) && reg_reset_req));

   // R5
   rst_busy_chk: assert property (@(posedge clk) disable iff (!por_n)
      rst_act |-> busy);

   // R7
   sticky_set_chk: assert property (@(posedge clk) disable iff (!por_n)
      (shdn_act && !rst_act) |=> shdn_seen);

endmodule

// File: tb/sdrst_ctrl_tb.sv
module sdrst_ctrl_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NP = 4;
   localparam int S  = 2;
   localparam int F  = 8;
   localparam int B  = 100;

   logic          clk = 1'b0;
   logic          por_n, shdn_n, rst_n, req, clr;
   logic [NP-1:0] mask;
   logic [NP-1:0] port_off;
   logic          reg_rst, busy, acc, rej, seen;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sdrst_ctrl #(.NUM_PORTS(NP), .SYNC_STAGES(S), .FILT_CYCLES(F), .BUSY_CYCLES(B)) u_dut (
      .clk(clk), .por_n(por_n), .shdn_pin_n(shdn_n), .rst_pin_n(rst_n),
      .prio_mask(mask), .host_cmd_req(req), .sticky_clr(clr),
      .port_off_req(port_off), .reg_reset_req(reg_rst), .busy(busy),
      .host_cmd_accept(acc), .host_cmd_reject(rej), .shdn_seen(seen)
   );

   task automatic chk(input string rq, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", rq, what, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic pulse_clr();
      clr = 1'b1; step(1); clr = 1'b0;
   endtask

   // filtered window: pin low on edges 1..w is active after edges S+F .. w+S+F-1
   function automatic bit in_win(input int k, input int w);
      return (w >= F) && (k >= S + F) && (k <= w + S + F - 1);
   endfunction

   function automatic bit busy_exp(input bit is_rst, input int k, input int w);
      return is_rst && (w >= F) && (k >= S + F) && (k < w + S + F + B);
   endfunction

   function automatic bit seen_exp(input bit is_rst, input int k, input int w);
      return !is_rst && (w >= F) && (k >= S + F + 1);
   endfunction

   task automatic run_pulse(input bit is_rst, input int w, input logic [NP-1:0] m);
      mask = m;
      req  = 1'b1;
      pulse_clr();
      if (is_rst) rst_n = 1'b0; else shdn_n = 1'b0;
      for (int k = 1; k <= w + S + F + B + 2; k++) begin
         logic [NP-1:0] eoff;
         step(1);
         eoff = in_win(k, w) ? (is_rst ? '1 : m) : '0;
         if (is_rst) chk("R4", "port_off_req", int'(port_off), int'(eoff));
         else        chk("R3", "port_off_req", int'(port_off), int'(eoff));
         chk("R2", "reg_reset_req", int'(reg_rst), int'(is_rst && in_win(k, w)));
         chk("R5", "busy", int'(busy), int'(busy_exp(is_rst, k, w)));
         chk("R6", "host_cmd_reject", int'(rej), int'(busy_exp(is_rst, k, w)));
         chk("R6", "host_cmd_accept", int'(acc), int'(!busy_exp(is_rst, k, w)));
         chk("R7", "shdn_seen", int'(seen), int'(seen_exp(is_rst, k, w)));
         if (k == w) begin
            shdn_n = 1'b1;
            rst_n  = 1'b1;
         end
      end
      req = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      por_n = 1'b0; shdn_n = 1'b1; rst_n = 1'b1; req = 1'b0; clr = 1'b0; mask = '0;
      repeat (3) @(negedge clk);

      // R8: POR holds the block idle even with both pins low
      shdn_n = 1'b0; rst_n = 1'b0;
      step(3);
      chk("R8", "port_off_req in por", int'(port_off), 0);
      chk("R8", "reg_reset_req in por", int'(reg_rst), 0);
      chk("R1", "busy in por", int'(busy), 1);
      chk("R1", "shdn_seen in por", int'(seen), 0);
      shdn_n = 1'b1; rst_n = 1'b1;
      step(1);

      // R1: startup window after POR release
      por_n = 1'b1;
      req   = 1'b1;
      for (int k = 1; k <= B + 2; k++) begin
         step(1);
         chk("R1", "busy after por", int'(busy), int'(k < B));
         chk("R6", "reject after por", int'(rej), int'(k < B));
         chk("R1", "port_off_req after por", int'(port_off), 0);
      end
      chk("R6", "accept idle", int'(acc), 1);
      req = 1'b0;
      #1;
      chk("R6", "accept no req", int'(acc), 0);
      chk("R6", "reject no req", int'(rej), 0);
      @(negedge clk);

      // R9: shutdown pin low across POR release
      mask = 4'b1010;
      por_n = 1'b0; shdn_n = 1'b0;
      step(1);
      por_n = 1'b1;
      for (int k = 1; k <= S + F + 1; k++) begin
         step(1);
         chk("R9", "port_off_req after por, pin low", int'(port_off),
             (k >= S + F) ? int'(mask) : 0);
      end
      shdn_n = 1'b1;
      step(B + S + F + 4);
      pulse_clr();

      // R2: one edge short versus exactly long enough
      run_pulse(1'b0, F - 1, 4'b1111);
      run_pulse(1'b0, F,     4'b0110);
      run_pulse(1'b1, F - 1, 4'b0000);
      run_pulse(1'b1, F,     4'b1001);

      // R7: clear ignored while shutdown is accepted, honoured afterwards
      mask = 4'b0101;
      shdn_n = 1'b0;
      step(S + F + 2);
      pulse_clr();
      step(1);
      chk("R7", "seen after clr during shutdown", int'(seen), 1);
      shdn_n = 1'b1;
      step(S + F + 1);
      chk("R3", "port_off_req after release", int'(port_off), 0);
      chk("R7", "seen held after release", int'(seen), 1);
      pulse_clr();
      chk("R7", "seen after clr", int'(seen), 0);

      // R4: reset overrides an active shutdown and clears the sticky flag
      mask = 4'b0011;
      shdn_n = 1'b0;
      step(S + F + 1);
      chk("R3", "port_off_req shutdown", int'(port_off), 3);
      rst_n = 1'b0;
      step(S + F + 1);
      chk("R4", "port_off_req reset over shutdown", int'(port_off), 15);
      chk("R4", "reg_reset_req", int'(reg_rst), 1);
      chk("R7", "seen cleared by reset", int'(seen), 0);
      rst_n = 1'b1;
      step(S + F + 1);
      chk("R3", "port_off_req back to mask", int'(port_off), 3);
      chk("R7", "seen set again", int'(seen), 1);
      chk("R5", "busy after reset release", int'(busy), 1);
      shdn_n = 1'b1;
      step(B + S + F + 2);
      pulse_clr();

      // R8: asynchronous POR in the middle of a shutdown
      shdn_n = 1'b0;
      step(S + F + 2);
      chk("R3", "port_off_req before por", int'(port_off), 3);
      #1 por_n = 1'b0;
      #1;
      chk("R8", "port_off_req async por", int'(port_off), 0);
      chk("R8", "shdn_seen async por", int'(seen), 0);
      chk("R8", "busy async por", int'(busy), 1);
      shdn_n = 1'b1;
      @(negedge clk);
      por_n = 1'b1;
      step(B + 2);

      // random pulses around the filter length
      for (int it = 0; it < 20; it++) begin
         bit            r;
         int            w;
         logic [NP-1:0] m;
         r = 1'($urandom_range(0, 1));
         w = int'($urandom_range(1, 2 * F + 2));
         m = NP'($urandom_range(0, (1 << NP) - 1));
         run_pulse(r, w, m);
      end

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule